// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block keeps the modem-side state of a 16550-style serial port. A five-bit control register drives four handshake outputs (request-to-send, data-terminal-ready and two general-purpose outputs) and selects an internal loopback. A status register reports the four incoming handshake lines (clear-to-send, data-set-ready, carrier detect, ring) and holds sticky change flags for them. Whenever the modem interrupt enable is set and any change flag is held, a modem interrupt request is raised.

Incoming lines pass through a two-flop synchronizer and are then compared against a registered copy each cycle. A change in carrier, data-set-ready or clear-to-send sets that line's change flag in either direction. The ring flag is set only when ring falls. Reading status outside loopback clears the flags. In loopback the control bits are routed to the status lines, the incoming pins are ignored, and the outgoing pins are held inactive. Interrupt arbitration against other sources and the serial data path belong to neighbouring blocks.

Top module: `mdm_ctl_stat`

## Requirements
- R1: After reset the control register reads 0x08 (only bit 3, general output 2, set). The status register reads 0xB0 (carrier, data-set-ready and clear-to-send high, ring low, no change flags). Only `out2_out` is high and `irq` is low.
- R2: A write with `reg_sel`=0 stores `wdata[4:0]`: bit 4 loopback, bit 3 general output 2, bit 2 general output 1, bit 1 request-to-send, bit 0 data-terminal-ready. A read with `reg_sel`=0 returns those five bits with the upper bits zero.
- R3: Outside loopback, `out2_out`, `out1_out`, `rts_out` and `dtr_out` follow control bits 3, 2, 1 and 0. In loopback all four are 0.
- R4: The status upper nibble is carrier (bit 7), ring (bit 6), data-set-ready (bit 5) and clear-to-send (bit 4). An input change is visible on the third rising clock edge after it is applied.
- R5: A change in either direction on carrier, data-set-ready or clear-to-send sets status bit 3, 1 or 0 respectively. The flag stays set until cleared by a status read.
- R6: Status bit 2 is set only when the ring line goes from 1 to 0. A rising ring line leaves it unchanged.
- R7: A status read (`rd_en`=1, `reg_sel`=1) outside loopback clears bits 3..0 at the clock edge of the read. A change that lands on that same edge keeps its flag set.
- R8: In loopback, the status upper nibble returns general output 2 as carrier, general output 1 as ring, data-terminal-ready as data-set-ready and request-to-send as clear-to-send. External inputs are ignored. Transitions of these looped values form change flags. A status read in loopback does not clear the flags.
- R9: `irq` is high exactly when `msi_en` is high and any of status bits 3..0 is set.
- R10: A write with `reg_sel`=1 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read clears change flags) |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register, combinational |
| msi_en | input | 1 | Modem interrupt enable |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| dcd_in | input | 1 | Carrier detect line, asynchronous |
| ri_in | input | 1 | Ring line, asynchronous |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Data-terminal-ready output |
| out1_out | output | 1 | General output 1 |
| out2_out | output | 1 | General output 2 |
| irq | output | 1 | Modem interrupt request |

## Verification
The bench raises and drops the ring line separately. A design that flags both edges would report a ring flag after the rising edge. It also lines up a status read with a clear-to-send change arriving on the same edge. A design where clear wins over set would lose that change for good. Loopback is entered and left with flags pending, which checks three things: flags must accumulate rather than be cleared by a loopback read, the looped values must replace the external pins, and leaving loopback must flag the jump back to the real line levels.

// File: rtl/mdm_pkg.sv
`timescale 1ns/1ps
// Shared types for the modem control/status block.
// Assumes the line nibble order carrier, ring, data-set-ready, clear-to-send
// (msb to lsb), which is also the order of the change flags.
package mdm_pkg;
    localparam int NUM_LINES = 4;
    localparam int CTL_W     = 5;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mctl_t;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mline_t;

    localparam mctl_t  CTL_RST  = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};
    localparam mline_t LINE_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
endpackage

// File: rtl/mdm_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer, one chain per line.
// Assumes STAGES >= 2; each chain resets to the matching bit of RST_VAL so
// that no false change is seen after reset when lines sit at idle level.
module mdm_sync #(
    parameter int              N       = 4,
    parameter int              STAGES  = 2,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic [STAGES-1:0] sh;
        // shift the raw line through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh <= {STAGES{RST_VAL[i]}};
            end else begin
                sh <= {sh[STAGES-2:0], async_in[i]};
            end
        end
        assign sync_out[i] = sh[STAGES-1];
    end
endmodule

// File: rtl/mdm_ctl_reg.sv
`timescale 1ns/1ps
// Control register: stores the five defined control bits on a write strobe.
// Assumes the caller passes only the stored bit slice of the write data.
module mdm_ctl_reg
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [CTL_W-1:0] wbits,
    output mctl_t            ctl_q
);
    // capture control bits on a write, reset to general output 2 only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else if (wr_stb) begin
            ctl_q <= mctl_t'(wbits);
        end
    end
endmodule

// File: rtl/mdm_delta.sv
`timescale 1ns/1ps
// Line state copy and sticky change flags.
// Compares the selected line source with the registered copy every cycle.
// Carrier, data-set-ready and clear-to-send flag both edges; ring flags only
// its falling edge. A clear request and a new change on the same edge leave
// the new change set.
module mdm_delta
    import mdm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  mline_t               src,
    input  logic                 clr,
    output mline_t               lines_q,
    output logic [NUM_LINES-1:0] delta_q
);
    mline_t               chg;
    logic [NUM_LINES-1:0] set_v;

    // per-line change events for this cycle
    always_comb begin
        chg   = lines_q ^ src;
        set_v = {chg.dcd, lines_q.ri & ~src.ri, chg.dsr, chg.cts};
    end

    // track the line copy and accumulate flags, set winning over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= LINE_RST;
            delta_q <= '0;
        end else begin
            lines_q <= src;
            delta_q <= (clr ? '0 : delta_q) | set_v;
        end
    end
endmodule

// File: rtl/mdm_ctl_stat.sv
`timescale 1ns/1ps
// Modem control and status register pair with internal loopback.
// Assumes reg_sel 0 = control, 1 = status; read data is combinational and a
// status read outside loopback clears change flags at the read's clock edge.
// Interrupt arbitration against other sources is done outside this block.
module mdm_ctl_stat
    import mdm_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              msi_en,
    input  logic              cts_in,
    input  logic              dsr_in,
    input  logic              dcd_in,
    input  logic              ri_in,
    output logic              rts_out,
    output logic              dtr_out,
    output logic              out1_out,
    output logic              out2_out,
    output logic              irq
);
    localparam int STAT_W = 2 * NUM_LINES;

    mctl_t                ctl_q;
    mline_t               ext_sync;
    mline_t               loop_map;
    mline_t               line_src;
    mline_t               lines_q;
    mline_t               line_view;
    logic [NUM_LINES-1:0] delta_q;
    logic                 stat_clr;
    logic                 wdata_unused;

    assign wdata_unused = ^wdata[DATA_W-1:CTL_W];

    mdm_ctl_reg u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_en && !reg_sel),
        .wbits  (wdata[CTL_W-1:0]),
        .ctl_q  (ctl_q)
    );

    mdm_sync #(
        .N       (NUM_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINE_RST)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dcd_in, ri_in, dsr_in, cts_in}),
        .sync_out (ext_sync)
    );

    // loopback cross map from control bits to status lines, and source pick
    always_comb begin
        loop_map.dcd = ctl_q.out2;
        loop_map.ri  = ctl_q.out1;
        loop_map.dsr = ctl_q.dtr;
        loop_map.cts = ctl_q.rts;
        line_src     = ctl_q.loop ? loop_map : ext_sync;
    end

    assign stat_clr = rd_en && reg_sel && !ctl_q.loop;

    mdm_delta u_delta (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (line_src),
        .clr     (stat_clr),
        .lines_q (lines_q),
        .delta_q (delta_q)
    );

    // status upper nibble: looped values directly in loopback, else line copy
    assign line_view = ctl_q.loop ? loop_map : lines_q;

    // read mux for the two registers
    always_comb begin
        if (reg_sel) begin
            rdata = DATA_W'({line_view, delta_q});
        end else begin
            rdata = DATA_W'(ctl_q);
        end
    end

    // external outputs, held inactive during loopback
    always_comb begin
        rts_out  = ctl_q.rts  && !ctl_q.loop;
        dtr_out  = ctl_q.dtr  && !ctl_q.loop;
        out1_out = ctl_q.out1 && !ctl_q.loop;
        out2_out = ctl_q.out2 && !ctl_q.loop;
    end

    assign irq = msi_en && (delta_q != '0);

    initial begin
        if (STAT_W > DATA_W) $display("mdm_ctl_stat: DATA_W too narrow");
    end
endmodule

// File: rtl/mdm_ctl_stat_chk.sv
`timescale 1ns/1ps
// Property checker for mdm_ctl_stat, bound to every instance of the top.
// Observes ports and the internal register outputs of the sub-blocks.
module mdm_ctl_stat_chk
    import mdm_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 reg_sel,
    input logic                 msi_en,
    input logic                 irq,
    input logic                 rts_out,
    input logic                 dtr_out,
    input logic                 out1_out,
    input logic                 out2_out,
    input logic                 stat_clr,
    input mctl_t                ctl_q,
    input mline_t               lines_q,
    input mline_t               line_src,
    input logic [NUM_LINES-1:0] delta_q
);
    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> msi_en);

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (delta_q != '0));

    // R5
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && (lines_q == line_src)) |=> (delta_q == '0));

    // R6
    ring_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[2]) |-> ($past(lines_q.ri) && !lines_q.ri));

    // R3
    loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.loop |-> !(rts_out || dtr_out || out1_out || out2_out));

    // R10
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !reg_sel) |=> $stable(ctl_q));
endmodule

bind mdm_ctl_stat mdm_ctl_stat_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .reg_sel  (reg_sel),
    .msi_en   (msi_en),
    .irq      (irq),
    .rts_out  (rts_out),
    .dtr_out  (dtr_out),
    .out1_out (out1_out),
    .out2_out (out2_out),
    .stat_clr (stat_clr),
    .ctl_q    (ctl_q),
    .lines_q  (lines_q),
    .line_src (line_src),
    .delta_q  (delta_q)
);

// File: tb/mdm_ctl_stat_bench.sv
`timescale 1ns/1ps
// Self-checking bench: vector table walk, then directed corner tests.
module mdm_ctl_stat_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       msi_en = 1'b1;
    logic       cts_in = 1'b1;
    logic       dsr_in = 1'b1;
    logic       dcd_in = 1'b1;
    logic       ri_in  = 1'b0;
    logic       rts_out, dtr_out, out1_out, out2_out, irq;

    int n_chk  = 0;
    int n_fail = 0;

    mdm_ctl_stat u_mdm_ctl_stat (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .msi_en(msi_en),
        .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in), .ri_in(ri_in),
        .rts_out(rts_out), .dtr_out(dtr_out), .out1_out(out1_out),
        .out2_out(out2_out), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // entry: {ext {dcd,ri,dsr,cts}, control byte, expected status, expected {out2,out1,rts,dtr}}
    localparam logic [20:0] VEC [10] = '{
        {4'b1011, 5'h03, 8'hB0, 4'b0011},  // R2 R3 no line change
        {4'b0011, 5'h03, 8'h38, 4'b0011},  // R5 carrier drop
        {4'b0111, 5'h0F, 8'h70, 4'b1111},  // R6 ring rise, no flag
        {4'b0011, 5'h0F, 8'h34, 4'b1111},  // R6 ring fall flags
        {4'b1100, 5'h04, 8'hCB, 4'b0100},  // R5 three lines at once
        {4'b1000, 5'h00, 8'h84, 4'b0000},  // R6 ring fall again
        {4'b1011, 5'h1F, 8'hF3, 4'b0000},  // R8 loopback all high, ext ignored
        {4'b1011, 5'h10, 8'h0F, 4'b0000},  // R8 flags accumulate, no clear
        {4'b1011, 5'h03, 8'hBF, 4'b0011},  // R8 leaving loopback flags jump
        {4'b1011, 5'h08, 8'hB0, 4'b1000}   // R7 previous read cleared
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_sel = sel;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_ext(input logic [3:0] v);
        @(negedge clk);
        {dcd_in, ri_in, dsr_in, cts_in} = v;
    endtask

    function automatic logic [7:0] outs();
        return {4'b0, out2_out, out1_out, rts_out, dtr_out};
    endfunction

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL R1-watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);

        // R1 reset state
        @(negedge clk);
        #1;
        chk("R1", "outputs", outs(), 8'h08);
        chk("R1", "irq", {7'b0, irq}, 8'h00);
        rd(1'b0, d); chk("R1", "control", d, 8'h08);
        rd(1'b1, d); chk("R1", "status", d, 8'hB0);

        // table walk
        for (int i = 0; i < 10; i++) begin
            logic [20:0] v;
            v = VEC[i];
            wr(1'b0, {3'b0, v[16:12]});
            set_ext(v[20:17]);
            repeat (3) @(posedge clk);
            @(negedge clk);
            #1;
            chk("R3", "outputs", outs(), {4'b0, v[3:0]});
            chk("R9", "irq", {7'b0, irq}, {7'b0, (v[7:4] != 4'b0)});
            rd(1'b0, d); chk("R2", "control", d, {3'b0, v[16:12]});
            rd(1'b1, d); chk("R4 R5 R6 R8", "status", d, v[11:4]);
        end

        // R7 read and change on the same edge: flag survives
        set_ext(4'b1010);
        repeat (2) @(posedge clk);
        rd(1'b1, d); chk("R7", "status before change", d, 8'hB0);
        rd(1'b1, d); chk("R7", "status after collision", d, 8'hA1);
        rd(1'b1, d); chk("R7", "status cleared", d, 8'hA0);

        // R9 enable gating
        msi_en = 1'b0;
        set_ext(4'b1011);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 chk("R9", "irq masked", {7'b0, irq}, 8'h00);
        msi_en = 1'b1;
        #1 chk("R9", "irq enabled", {7'b0, irq}, 8'h01);
        rd(1'b1, d); chk("R5", "status cts rise", d, 8'hB1);
        #1 chk("R9", "irq after clear", {7'b0, irq}, 8'h00);

        // R10 status write ignored
        wr(1'b1, 8'hFF);
        rd(1'b1, d); chk("R10", "status after write", d, 8'hB0);
        rd(1'b0, d); chk("R10", "control after status write", d, 8'h08);

        // R2 upper write bits dropped
        wr(1'b0, 8'hE6);
        rd(1'b0, d); chk("R2", "control masked", d, 8'h06);
        #1 chk("R3", "outputs masked write", outs(), 8'h06);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule